// File: doc/BRIEF.md
# Interrupt Entry and Return Unit

This block owns the program counter and the interrupt state of a simple processor core. It has one enable flag and no priority scheme. At each instruction boundary, flagged by `fetch_start_i`, it either advances the PC by four or takes an external interrupt. An interrupt is taken only when a request is present and the enable flag is set. When it is taken, the unit does four things on the same clock edge: it stores the current PC and the 16-bit source information, clears the enable flag, and loads the PC with a vector built from the 8-bit source code. It then raises acknowledge for exactly one cycle.

Between boundaries, the execution stage sends the unit commands through `cmd_valid_i` and a 5-bit opcode. The commands are:
- enable interrupts,
- disable interrupts,
- save the interrupt state to the register file,
- restore the interrupt state from the register file,
- return from a handler, which restores the PC and re-enables interrupts in one step.

The controller has two states. In `ST_RUN` it accepts boundaries and commands. The transition `take` moves it to `ST_ENTER` on an interrupt boundary. In `ST_ENTER` acknowledge is high and every input except reset is ignored. The transition `release` always returns it to `ST_RUN` on the next edge.

Top module: `irq_entry_unit`

## Requirements
- R1: On interrupt entry the PC becomes a word whose bits 11..4 hold `irq_code_i` and whose bits 31..12 and 3..0 are zero.
- R2: Entry happens only on an edge where the unit is in `ST_RUN`, `fetch_start_i`=1, `irq_req_i`=1 and the enable flag is 1. A request seen while the flag is 0 is not remembered.
- R3: On the entry edge, the saved PC takes the current PC, the info register takes `irq_info_i`, and the enable flag clears.
- R4: `irq_ack_o` is 1 for exactly the one cycle after the entry edge. In that cycle the unit ignores `fetch_start_i` and commands.
- R5: A boundary in `ST_RUN` that does not take an interrupt increments the PC by 4.
- R6: Return (opcode 29) loads the PC from the saved PC and sets the enable flag on one edge. If a non-interrupt boundary arrives in the same cycle, the return value wins over PC+4.
- R7: Enable (opcode 10) sets the flag and disable (opcode 11) clears it. The interrupt check at a boundary in the same cycle uses the flag value from before the command.
- R8: Save (opcode 16) drives `save_we_o`=1 in the same cycle, with `save_info_o` equal to the info register and `save_pc_o` equal to the saved PC. Save changes no state.
- R9: Restore (opcode 17) loads the info register from `rs_info_i` and the saved PC from `rs_pc_i`.
- R10: A command arriving on an entry edge is dropped. An opcode other than 10, 11, 16, 17 or 29 changes nothing.
- R11: Reset (async, active low) sets the PC to 0 and clears the enable flag, the saved PC, the info register and acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_start_i | input | 1 | Instruction boundary strobe |
| irq_req_i | input | 1 | External interrupt request, held by the device |
| irq_code_i | input | 8 | Source type code used to form the vector |
| irq_info_i | input | 16 | Source information captured on entry |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 5 | Command opcode |
| rs_info_i | input | 16 | Register value (low half) used by restore for the info register |
| rs_pc_i | input | 32 | Register value used by restore for the saved PC |
| pc_o | output | 32 | Program counter |
| irq_ack_o | output | 1 | Interrupt acknowledge pulse |
| int_en_o | output | 1 | Interrupt enable flag |
| save_we_o | output | 1 | Register write strobe for save |
| save_info_o | output | 16 | Info register value for save |
| save_pc_o | output | 32 | Saved PC value for save |

## Verification
The instruction boundary and a command can land on the same edge, and this case is provoked deliberately. Three same-cycle pairs are driven:
- enable together with a pending request while the flag is off, where the request must not be taken;
- return together with a taken interrupt, where the return is dropped;
- return together with a plain boundary, where the PC takes the saved value rather than PC+4.

Each result is judged one edge later from the PC, the flag, acknowledge and the saved registers. A boundary and a command are also driven during the acknowledge cycle, and they must leave all state untouched.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [4:0] {
        OPC_ENABLE  = 5'd10,
        OPC_DISABLE = 5'd11,
        OPC_SAVE    = 5'd16,
        OPC_RESTORE = 5'd17,
        OPC_RETURN  = 5'd29
    } op_code_e;

    typedef enum logic [1:0] {
        PC_HOLD,
        PC_INC,
        PC_VEC,
        PC_RET
    } pc_sel_e;

    typedef enum logic {
        ST_RUN,
        ST_ENTER
    } ctl_state_e;

endpackage

// File: rtl/irq_vec_build.sv
module irq_vec_build #(
    parameter int XLEN    = 32,
    parameter int CODE_W  = 8,
    parameter int VEC_LSB = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   vec_o
);
    localparam int VEC_MSB = VEC_LSB + CODE_W - 1;

    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        if (b >= VEC_LSB && b <= VEC_MSB) begin : g_code
            assign vec_o[b] = code_i[b - VEC_LSB];
        end else begin : g_zero
            assign vec_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_entry_pkg::*;
(
    input  logic       valid_i,
    input  logic [4:0] op_i,
    output logic       en_o,
    output logic       dis_o,
    output logic       save_o,
    output logic       rest_o,
    output logic       ret_o
);
    always_comb begin
        en_o   = 1'b0;
        dis_o  = 1'b0;
        save_o = 1'b0;
        rest_o = 1'b0;
        ret_o  = 1'b0;
        if (valid_i) begin
            case (op_i)
                OPC_ENABLE:  en_o   = 1'b1;
                OPC_DISABLE: dis_o  = 1'b1;
                OPC_SAVE:    save_o = 1'b1;
                OPC_RESTORE: rest_o = 1'b1;
                OPC_RETURN:  ret_o  = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/irq_pc_reg.sv
module irq_pc_reg
    import irq_entry_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_sel_e         sel_i,
    input  logic [XLEN-1:0] vec_i,
    input  logic [XLEN-1:0] ret_i,
    output logic [XLEN-1:0] pc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;

    always_comb begin
        unique case (sel_i)
            PC_HOLD: pc_d = pc_q;
            PC_INC:  pc_d = pc_q + STEP;
            PC_VEC:  pc_d = vec_i;
            PC_RET:  pc_d = ret_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (sel_i == PC_INC) |=> (pc_o == $past(pc_o) + STEP)); // R5
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              INFO_W   = 16,
    parameter int              CODE_W   = 8,
    parameter int              VEC_LSB  = 4,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_start_i,
    input  logic              irq_req_i,
    input  logic [CODE_W-1:0] irq_code_i,
    input  logic [INFO_W-1:0] irq_info_i,
    input  logic              cmd_valid_i,
    input  logic [4:0]        cmd_op_i,
    input  logic [INFO_W-1:0] rs_info_i,
    input  logic [XLEN-1:0]   rs_pc_i,
    output logic [XLEN-1:0]   pc_o,
    output logic              irq_ack_o,
    output logic              int_en_o,
    output logic              save_we_o,
    output logic [INFO_W-1:0] save_info_o,
    output logic [XLEN-1:0]   save_pc_o
);
    localparam int VEC_TOP = VEC_LSB + CODE_W;

    ctl_state_e        state_q, state_d;
    logic              ie_q, ie_d;
    logic [XLEN-1:0]   ipc_q, ipc_d;
    logic [INFO_W-1:0] info_q, info_d;
    logic [XLEN-1:0]   vec;
    pc_sel_e           pc_sel;
    logic              in_run, take, cmd_ok;
    logic              op_en, op_dis, op_save, op_rest, op_ret;

    irq_vec_build #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W),
        .VEC_LSB(VEC_LSB)
    ) i_vec (
        .code_i(irq_code_i),
        .vec_o (vec)
    );

    assign in_run = (state_q == ST_RUN);
    assign take   = in_run && fetch_start_i && irq_req_i && ie_q;
    assign cmd_ok = cmd_valid_i && in_run && !take;

    irq_cmd_decode i_dec (
        .valid_i(cmd_ok),
        .op_i   (cmd_op_i),
        .en_o   (op_en),
        .dis_o  (op_dis),
        .save_o (op_save),
        .rest_o (op_rest),
        .ret_o  (op_ret)
    );

    irq_pc_reg #(
        .XLEN    (XLEN),
        .RESET_PC(RESET_PC)
    ) i_pc (
        .clk  (clk),
        .rst_n(rst_n),
        .sel_i(pc_sel),
        .vec_i(vec),
        .ret_i(ipc_q),
        .pc_o (pc_o)
    );

    // next state and data
    always_comb begin
        state_d = state_q;
        ie_d    = ie_q;
        ipc_d   = ipc_q;
        info_d  = info_q;
        pc_sel  = PC_HOLD;
        unique case (state_q)
            ST_RUN: begin
                if (take) begin
                    state_d = ST_ENTER;
                    ie_d    = 1'b0;
                    ipc_d   = pc_o;
                    info_d  = irq_info_i;
                    pc_sel  = PC_VEC;
                end else begin
                    if (op_ret)             pc_sel = PC_RET;
                    else if (fetch_start_i) pc_sel = PC_INC;
                    if (op_ret || op_en)    ie_d   = 1'b1;
                    else if (op_dis)        ie_d   = 1'b0;
                    if (op_rest) begin
                        ipc_d  = rs_pc_i;
                        info_d = rs_info_i;
                    end
                end
            end
            ST_ENTER: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            ie_q    <= 1'b0;
            ipc_q   <= '0;
            info_q  <= '0;
        end else begin
            state_q <= state_d;
            ie_q    <= ie_d;
            ipc_q   <= ipc_d;
            info_q  <= info_d;
        end
    end

    // outputs
    always_comb begin
        irq_ack_o   = (state_q == ST_ENTER);
        int_en_o    = ie_q;
        save_we_o   = op_save;
        save_info_o = info_q;
        save_pc_o   = ipc_q;
    end

    AST_VEC_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n) irq_ack_o |-> (pc_o[VEC_LSB-1:0] == '0 && pc_o[XLEN-1:VEC_TOP] == '0)); // R1
    AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (in_run && fetch_start_i && !int_en_o) |=> !irq_ack_o); // R2
    AST_ENTRY_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n) take |=> (save_pc_o == $past(pc_o))); // R3
    AST_ENTRY_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n) irq_ack_o |-> !int_en_o); // R3
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq_ack_o |=> !irq_ack_o); // R4
    AST_ENTER_FREEZES: assert property (@(posedge clk) disable iff (!rst_n) irq_ack_o |=> ($stable(pc_o) && $stable(int_en_o))); // R4
    AST_RET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n) op_ret |=> (int_en_o && pc_o == $past(save_pc_o))); // R6
endmodule

// File: tb/test_irq_entry_unit.sv
`timescale 1ns/1ps
module test_irq_entry_unit;

    typedef struct packed {
        logic        fetch;
        logic        req;
        logic [7:0]  code;
        logic [15:0] info;
        logic        cv;
        logic [4:0]  op;
        logic [15:0] ra;
        logic [31:0] rb;
        logic [31:0] epc;
        logic        eie;
        logic        eack;
        logic [31:0] eipc;
        logic [15:0] einfo;
    } row_t;

    localparam int NROWS = 15;
    localparam row_t TBL [NROWS] = '{
        '{1'b1,1'b1,8'h00,16'h0000,1'b0,5'd0 ,16'h0000,32'h0,32'h0000_0004,1'b0,1'b0,32'h0000_0000,16'h0000},
        '{1'b0,1'b0,8'h00,16'h0000,1'b1,5'd10,16'h0000,32'h0,32'h0000_0004,1'b1,1'b0,32'h0000_0000,16'h0000},
        '{1'b1,1'b0,8'h00,16'h0000,1'b0,5'd0 ,16'h0000,32'h0,32'h0000_0008,1'b1,1'b0,32'h0000_0000,16'h0000},
        '{1'b1,1'b1,8'hA5,16'h1234,1'b0,5'd0 ,16'h0000,32'h0,32'h0000_0A50,1'b0,1'b1,32'h0000_0008,16'h1234},
        '{1'b0,1'b0,8'h00,16'h0000,1'b0,5'd0 ,16'h0000,32'h0,32'h0000_0A50,1'b0,1'b0,32'h0000_0008,16'h1234},
        '{1'b1,1'b0,8'h00,16'h0000,1'b0,5'd0 ,16'h0000,32'h0,32'h0000_0A54,1'b0,1'b0,32'h0000_0008,16'h1234},
        '{1'b0,1'b0,8'h00,16'h0000,1'b1,5'd16,16'h0000,32'h0,32'h0000_0A54,1'b0,1'b0,32'h0000_0008,16'h1234},
        '{1'b0,1'b0,8'h00,16'h0000,1'b1,5'd17,16'hBEEF,32'h100,32'h0000_0A54,1'b0,1'b0,32'h0000_0100,16'hBEEF},
        '{1'b0,1'b0,8'h00,16'h0000,1'b1,5'd29,16'h0000,32'h0,32'h0000_0100,1'b1,1'b0,32'h0000_0100,16'hBEEF},
        '{1'b0,1'b0,8'h00,16'h0000,1'b1,5'd11,16'h0000,32'h0,32'h0000_0100,1'b0,1'b0,32'h0000_0100,16'hBEEF},
        '{1'b1,1'b1,8'h33,16'h5555,1'b1,5'd10,16'h0000,32'h0,32'h0000_0104,1'b1,1'b0,32'h0000_0100,16'hBEEF},
        '{1'b1,1'b1,8'hFF,16'hCAFE,1'b1,5'd29,16'h0000,32'h0,32'h0000_0FF0,1'b0,1'b1,32'h0000_0104,16'hCAFE},
        '{1'b1,1'b1,8'h11,16'h7777,1'b1,5'd10,16'h0000,32'h0,32'h0000_0FF0,1'b0,1'b0,32'h0000_0104,16'hCAFE},
        '{1'b1,1'b0,8'h00,16'h0000,1'b1,5'd29,16'h0000,32'h0,32'h0000_0104,1'b1,1'b0,32'h0000_0104,16'hCAFE},
        '{1'b0,1'b0,8'h00,16'h0000,1'b1,5'd5 ,16'hAAAA,32'h999,32'h0000_0104,1'b1,1'b0,32'h0000_0104,16'hCAFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_start_i = 1'b0;
    logic        irq_req_i = 1'b0;
    logic [7:0]  irq_code_i = '0;
    logic [15:0] irq_info_i = '0;
    logic        cmd_valid_i = 1'b0;
    logic [4:0]  cmd_op_i = '0;
    logic [15:0] rs_info_i = '0;
    logic [31:0] rs_pc_i = '0;
    logic [31:0] pc_o;
    logic        irq_ack_o;
    logic        int_en_o;
    logic        save_we_o;
    logic [15:0] save_info_o;
    logic [31:0] save_pc_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_entry_unit i_irq_entry_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_start_i(fetch_start_i),
        .irq_req_i    (irq_req_i),
        .irq_code_i   (irq_code_i),
        .irq_info_i   (irq_info_i),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_op_i     (cmd_op_i),
        .rs_info_i    (rs_info_i),
        .rs_pc_i      (rs_pc_i),
        .pc_o         (pc_o),
        .irq_ack_o    (irq_ack_o),
        .int_en_o     (int_en_o),
        .save_we_o    (save_we_o),
        .save_info_o  (save_info_o),
        .save_pc_o    (save_pc_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0:  return "R2";
            1:  return "R7";
            2:  return "R5";
            3:  return "R1/R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R8";
            7:  return "R9";
            8:  return "R6";
            9:  return "R7";
            10: return "R7";
            11: return "R10";
            12: return "R4";
            13: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic idle_inputs();
        fetch_start_i = 1'b0;
        irq_req_i     = 1'b0;
        irq_code_i    = '0;
        irq_info_i    = '0;
        cmd_valid_i   = 1'b0;
        cmd_op_i      = '0;
        rs_info_i     = '0;
        rs_pc_i       = '0;
    endtask

    task automatic check_state(input string req, input logic [31:0] pc, input logic ie, input logic ack,
                               input logic [31:0] ipc, input logic [15:0] info);
        chk(req, "pc", pc_o, pc);
        chk(req, "int_en", {31'b0, int_en_o}, {31'b0, ie});
        chk(req, "ack", {31'b0, irq_ack_o}, {31'b0, ack});
        chk(req, "saved_pc", save_pc_o, ipc);
        chk(req, "info", {16'b0, save_info_o}, {16'b0, info});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        idle_inputs();
        repeat (3) @(negedge clk);
        // R11 reset state
        check_state("R11", 32'h0, 1'b0, 1'b0, 32'h0, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R11", 32'h0, 1'b0, 1'b0, 32'h0, 16'h0);

        for (int i = 0; i < NROWS; i++) begin
            fetch_start_i = TBL[i].fetch;
            irq_req_i     = TBL[i].req;
            irq_code_i    = TBL[i].code;
            irq_info_i    = TBL[i].info;
            cmd_valid_i   = TBL[i].cv;
            cmd_op_i      = TBL[i].op;
            rs_info_i     = TBL[i].ra;
            rs_pc_i       = TBL[i].rb;
            @(posedge clk);
            @(negedge clk);
            check_state(row_tag(i), TBL[i].epc, TBL[i].eie, TBL[i].eack, TBL[i].eipc, TBL[i].einfo);
        end
        idle_inputs();

        // R8 save: strobe and data in the same cycle, no state change afterwards
        cmd_valid_i = 1'b1;
        cmd_op_i    = 5'd16;
        #1;
        chk("R8", "save_we", {31'b0, save_we_o}, 32'h1);
        chk("R8", "save_info", {16'b0, save_info_o}, 32'h0000_CAFE);
        chk("R8", "save_pc", save_pc_o, 32'h0000_0104);
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        #1;
        chk("R8", "save_we idle", {31'b0, save_we_o}, 32'h0);
        check_state("R8", 32'h104, 1'b1, 1'b0, 32'h104, 16'hCAFE);

        // R1 vector with zero code
        @(negedge clk);
        fetch_start_i = 1'b1;
        irq_req_i     = 1'b1;
        irq_code_i    = 8'h00;
        irq_info_i    = 16'h0F0F;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check_state("R1", 32'h0, 1'b0, 1'b1, 32'h104, 16'h0F0F);

        // R11 reset in mid-operation
        cmd_valid_i = 1'b1;
        cmd_op_i    = 5'd10;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        cmd_valid_i = 1'b1;
        cmd_op_i    = 5'd10;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        chk("R7", "int_en", {31'b0, int_en_o}, 32'h1);
        rst_n = 1'b0;
        #1;
        check_state("R11", 32'h0, 1'b0, 1'b0, 32'h0, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R11", 32'h0, 1'b0, 1'b0, 32'h0, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule